// File: doc/BRIEF.md
# Read-Only Set-Associative Fetch Cache with Block-Grouped Set Index

This block is a read-only data cache for texture-style fetch traffic. A client presents word addresses over a valid/ready handshake and receives the 32-bit word, plus a flag that says whether the word was already resident. When a word is absent, the cache reads its whole line from a simple backing-memory read port, one word per beat, installs the line, and then answers. Nothing is ever written into the cache except lines fetched from below.

The set index does not come from the address bits just above the line offset. It comes from the next bits up, so all four lines of an aligned 128-byte block land in the same set, and the following block lands in the next set. A fetch pattern that walks a small two-dimensional tile therefore spreads over the sets block by block rather than line by line. To keep every line distinct, the tag holds the two line-in-block bits as well as the bits above the set field. With the default sizes the cache holds 12 KB: 4 sets of 96 ways, 8 words per line. The way count is a parameter so that the same RTL can be verified at low associativity. Replacement is true least-recently-used within each set.

Top module: `rocache_top`

## Requirements
- R1: After a synchronous active-low reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: Word address bits [2:0] select the word in a line. Word address bits [6:5] (byte bits [8:7]) select the set. The tag is word address bits above bit 6 joined with bits [4:3]. As a result, the four lines of one 128-byte block compete for the ways of a single set.
- R3: A read of a resident line returns the addressed word with rsp_hit=1 on the second rising edge after acceptance, and issues no backing-memory reads.
- R4: A read of an absent line drives mem_req with mem_addr walking the eight words of the line in ascending order from the line base. mem_addr is held until mem_rvalid accepts each beat. After the eighth beat the cache returns the addressed word with rsp_hit=0.
- R5: req_ready is 0 from the cycle after a request is accepted until the response is given, so only one request is outstanding at a time.
- R6: rsp_valid is high for exactly one cycle per accepted request.
- R7: When all ways of the target set are valid, a miss evicts the least-recently-used line of that set. Both hits and fills count as uses.
- R8: A miss fills an invalid way before it evicts any valid line, so a set holding fewer than NUM_WAYS lines never loses one.
- R9: A one-cycle pulse on inv_all makes every line invalid, so the next read of any previously resident line misses.
- R10: Lines in different sets never evict one another.
- R11: Every returned word equals the backing-memory word at the requested address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Invalidate every line and reset replacement order |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response word valid (one-cycle pulse) |
| rsp_data | output | 32 | Returned word |
| rsp_hit | output | 1 | 1 when the line was resident |
| mem_req | output | 1 | Backing-memory read beat requested |
| mem_addr | output | ADDR_W | Word address of the current fill beat |
| mem_rvalid | input | 1 | Backing memory delivers mem_rdata for mem_addr |
| mem_rdata | input | 32 | Backing-memory word |

## Verification
The checker watches the handshake rules on every cycle: req_ready stays low while a request is outstanding and during a fill, and rsp_valid is a single-cycle pulse. It also checks that a fill beat's address holds steady until it is accepted, that every fill beat stays inside the requested line, and that a hit response never follows backing-memory traffic while a miss always does. For a miss, the checker confirms that the returned word is the one delivered for the requested address. Which line is evicted, whether the four lines of a block really share a set, set independence, and the effect of invalidation can only be shown by the bench. It does this by comparing the hit flag of each read against a replacement model that applies the same address mapping, using directed conflict sequences and random traffic.

// File: rtl/rocache_pkg.sv
// Shared definitions for the read-only fetch cache.
// Assumes: fixed 32-bit data words; the controller is a three-state machine.
package rocache_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/rocache_addr_split.sv
// Splits a word address into word offset, set index and tag.
// The set field sits above the line-in-block field, so one aligned block of
// LINES_PER_BLOCK lines maps to a single set; the line-in-block bits join the tag.
// Assumes: all geometry parameters are powers of two.
module rocache_addr_split #(
    parameter int ADDR_W          = 24,
    parameter int WORDS_PER_LINE  = 8,
    parameter int LINES_PER_BLOCK = 4,
    parameter int NUM_SETS        = 4,
    localparam int OFF_W = $clog2(WORDS_PER_LINE),
    localparam int LB_W  = $clog2(LINES_PER_BLOCK),
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  word_off,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int SET_LO = OFF_W + LB_W;
    localparam int HI_LO  = SET_LO + SET_W;

    // Field extraction with the set bits lifted above the line-in-block bits.
    always_comb begin
        word_off = addr[OFF_W-1:0];
        set_idx  = addr[SET_LO +: SET_W];
        tag      = {addr[ADDR_W-1:HI_LO], addr[SET_LO-1:OFF_W]};
    end
endmodule

// File: rtl/rocache_tag_store.sv
// Tag, valid and replacement state for every set and way.
// Lookup is combinational on (lk_set, lk_tag). Replacement keeps a rank per way
// (0 = most recent, NUM_WAYS-1 = least recent) forming a permutation per set.
// Victim choice: lowest-numbered invalid way, else the rank NUM_WAYS-1 way.
// Assumes: NUM_WAYS >= 2; inv_all takes priority over any update that cycle.
module rocache_tag_store #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 96,
    parameter int TAG_W    = 19,
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int WAY_W  = $clog2(NUM_WAYS),
    localparam int RANK_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             inst_en,
    input  logic [TAG_W-1:0] inst_tag
);
    logic              valid_q [NUM_SETS][NUM_WAYS];
    logic [TAG_W-1:0]  tag_q   [NUM_SETS][NUM_WAYS];
    logic [RANK_W-1:0] rank_q  [NUM_SETS][NUM_WAYS];
    logic              free_found;
    logic              hit_found;

    // Tag compare across the ways of the looked-up set, lowest match wins.
    always_comb begin
        hit_found = 1'b0;
        hit_way   = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!hit_found && valid_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
                hit_found = 1'b1;
                hit_way   = WAY_W'(w);
            end
        end
        hit = hit_found;
    end

    // Victim selection: first free way, otherwise the least recently used.
    always_comb begin
        free_found = 1'b0;
        victim_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!free_found && !valid_q[lk_set][w]) begin
                free_found = 1'b1;
                victim_way = WAY_W'(w);
            end
        end
        if (!free_found) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (rank_q[lk_set][w] == RANK_W'(NUM_WAYS - 1)) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

    // Valid bits and recency ranks: reset/invalidate, then promote on use.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    rank_q[s][w]  <= RANK_W'(NUM_WAYS - 1 - w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    rank_q[lk_set][w] <= '0;
                end else if (rank_q[lk_set][w] < rank_q[lk_set][upd_way]) begin
                    rank_q[lk_set][w] <= rank_q[lk_set][w] + 1'b1;
                end
            end
            if (inst_en) begin
                valid_q[lk_set][upd_way] <= 1'b1;
            end
        end
    end

    // Tag payload written when a filled line is installed.
    always_ff @(posedge clk) begin
        if (upd_en && inst_en) begin
            tag_q[lk_set][upd_way] <= inst_tag;
        end
    end
endmodule

// File: rtl/rocache_data_store.sv
// Line data array: one write port for fill beats, one combinational read port.
// Assumes: the reader and writer never target the same word in one cycle.
module rocache_data_store #(
    parameter int NUM_SETS       = 4,
    parameter int NUM_WAYS       = 96,
    parameter int WORDS_PER_LINE = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int OFF_W = $clog2(WORDS_PER_LINE),
    localparam int DEPTH = NUM_SETS * NUM_WAYS * WORDS_PER_LINE,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [SET_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [rocache_pkg::DATA_W-1:0] wr_data,
    input  logic [SET_W-1:0]              rd_set,
    input  logic [WAY_W-1:0]              rd_way,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [rocache_pkg::DATA_W-1:0] rd_data
);
    logic [rocache_pkg::DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    function automatic logic [IDX_W-1:0] flat_idx(input logic [SET_W-1:0] s,
                                                  input logic [WAY_W-1:0] w,
                                                  input logic [OFF_W-1:0] o);
        return (IDX_W'(s) * IDX_W'(NUM_WAYS) + IDX_W'(w)) * IDX_W'(WORDS_PER_LINE)
               + IDX_W'(o);
    endfunction

    // Flat word indices for both ports.
    always_comb begin
        wr_idx  = flat_idx(wr_set, wr_way, wr_off);
        rd_idx  = flat_idx(rd_set, rd_way, rd_off);
        rd_data = mem_q[rd_idx];
    end

    // Fill beat write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/rocache_top.sv
// Read-only set-associative fetch cache, top level.
// A request is latched, looked up in the following cycle, and either answered
// from the array (hit) or filled from backing memory one word per beat,
// starting at the line base, before the answer is given (miss).
// Assumes: backing memory answers each beat for the address shown on mem_addr.
module rocache_top #(
    parameter int ADDR_W          = 24,
    parameter int WORDS_PER_LINE  = 8,
    parameter int LINES_PER_BLOCK = 4,
    parameter int NUM_SETS        = 4,
    parameter int NUM_WAYS        = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    import rocache_pkg::*;

    localparam int OFF_W = $clog2(WORDS_PER_LINE);
    localparam int SET_W = $clog2(NUM_SETS);
    localparam int WAY_W = $clog2(NUM_WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    ctl_state_t        state_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [WAY_W-1:0]  victim_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] cap_q;

    logic [OFF_W-1:0]  cur_off;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic              ts_hit;
    logic [WAY_W-1:0]  ts_hit_way;
    logic [WAY_W-1:0]  ts_victim;
    logic              upd_en;
    logic [WAY_W-1:0]  upd_way;
    logic              inst_en;
    logic              beat_take;
    logic              last_beat;
    logic [DATA_W-1:0] arr_rd;

    rocache_addr_split #(
        .ADDR_W(ADDR_W), .WORDS_PER_LINE(WORDS_PER_LINE),
        .LINES_PER_BLOCK(LINES_PER_BLOCK), .NUM_SETS(NUM_SETS)
    ) split_i (
        .addr(lat_addr_q), .word_off(cur_off), .set_idx(cur_set), .tag(cur_tag)
    );

    rocache_tag_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
    ) tags_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_set(cur_set), .lk_tag(cur_tag),
        .hit(ts_hit), .hit_way(ts_hit_way), .victim_way(ts_victim),
        .upd_en(upd_en), .upd_way(upd_way), .inst_en(inst_en), .inst_tag(cur_tag)
    );

    rocache_data_store #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .WORDS_PER_LINE(WORDS_PER_LINE)
    ) data_i (
        .clk(clk),
        .wr_en(beat_take), .wr_set(cur_set), .wr_way(victim_q), .wr_off(beat_q),
        .wr_data(mem_rdata),
        .rd_set(cur_set), .rd_way(ts_hit_way), .rd_off(cur_off), .rd_data(arr_rd)
    );

    // Handshake, fill-port and tag-update controls decoded from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_FILL);
        mem_addr  = {lat_addr_q[ADDR_W-1:OFF_W], beat_q};
        beat_take = (state_q == ST_FILL) && mem_rvalid;
        last_beat = (beat_q == OFF_W'(WORDS_PER_LINE - 1));
        inst_en   = (state_q == ST_FILL);
        upd_en    = ((state_q == ST_LOOKUP) && ts_hit) || (beat_take && last_beat);
        upd_way   = (state_q == ST_LOOKUP) ? ts_hit_way : victim_q;
    end

    // Controller: accept, look up, fill on a miss, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_addr_q <= '0;
            victim_q   <= '0;
            beat_q     <= '0;
            cap_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_hit    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_addr_q <= req_addr;
                        state_q    <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (ts_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_data  <= arr_rd;
                        state_q   <= ST_IDLE;
                    end else begin
                        victim_q <= ts_victim;
                        beat_q   <= '0;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rvalid) begin
                        if (beat_q == cur_off) begin
                            cap_q <= mem_rdata;
                        end
                        if (last_beat) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_data  <= (beat_q == cur_off) ? mem_rdata : cap_q;
                            state_q   <= ST_IDLE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rocache_checker.sv
// Protocol checker for the fetch cache, bound to the top module.
// Tracks the accepted address, whether any fill beat followed it, and the
// word delivered for that address, and relates them to the responses.
module rocache_checker #(
    parameter int ADDR_W         = 24,
    parameter int WORDS_PER_LINE = 8,
    localparam int OFF_W = $clog2(WORDS_PER_LINE)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [31:0]       rsp_data,
    input logic              rsp_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic [31:0]       mem_rdata
);
    logic [ADDR_W-1:0] cap_addr;
    logic              fill_seen;
    logic [31:0]       cap_word;

    // Observation of the current request and its fill traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            fill_seen <= 1'b0;
            cap_word  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                cap_addr  <= req_addr;
                fill_seen <= 1'b0;
            end
            if (mem_req && mem_rvalid) begin
                fill_seen <= 1'b1;
                if (mem_addr == cap_addr) begin
                    cap_word <= mem_rdata;
                end
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_req));

    assert_fill_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:OFF_W] == cap_addr[ADDR_W-1:OFF_W]));

    assert_hit_no_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !fill_seen);

    assert_miss_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> fill_seen);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_busy_in_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_miss_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == cap_word));
endmodule

bind rocache_top rocache_checker #(
    .ADDR_W(ADDR_W), .WORDS_PER_LINE(WORDS_PER_LINE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/rocache_top_tb_top.sv
`timescale 1ns/1ps
// Bench for the fetch cache at reduced associativity, with a replacement
// scoreboard that applies the required address mapping and LRU order.
module rocache_top_tb_top;
    localparam int AW   = 12;
    localparam int WAYS = 4;
    localparam int SETS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv_all = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic          rsp_hit;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    int tests = 0;
    int fails = 0;
    int beat_cnt = 0;
    logic [AW-1:0] beat_log [16];

    int m_valid [SETS][WAYS];
    int m_line  [SETS][WAYS];
    int m_stamp [SETS][WAYS];
    int stamp = 0;

    always #2 clk = ~clk;

    rocache_top #(.ADDR_W(AW), .NUM_WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_valid[s][w] = 0;
    endfunction

    // Scoreboard access: returns expected hit flag and updates the model.
    // Line = word address / 8; set = (line / 4) mod 4 (the R2 mapping).
    function automatic bit model_access(input int waddr);
        int line = waddr / 8;
        int s = (line / 4) % SETS;
        int vic = -1;
        stamp++;
        for (int w = 0; w < WAYS; w++) begin
            if (m_valid[s][w] != 0 && m_line[s][w] == line) begin
                m_stamp[s][w] = stamp;
                return 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++)
            if (vic < 0 && m_valid[s][w] == 0) vic = w;
        if (vic < 0) begin
            vic = 0;
            for (int w = 1; w < WAYS; w++)
                if (m_stamp[s][w] < m_stamp[s][vic]) vic = w;
        end
        m_valid[s][vic] = 1;
        m_line[s][vic]  = line;
        m_stamp[s][vic] = stamp;
        return 1'b0;
    endfunction

    // Backing memory: random stalls, logs every accepted beat address.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                mem_rvalid = ($urandom % 4) != 0;
                mem_rdata  = mem_word(mem_addr);
                if (mem_rvalid && beat_cnt < 16) begin
                    beat_log[beat_cnt] = mem_addr;
                    beat_cnt++;
                end
            end else begin
                mem_rvalid = 1'b0;
            end
        end
    end

    // One read with full checking; req names the requirement being stressed.
    task automatic do_read(input int waddr, input string req);
        bit exp_hit;
        int lat;
        bit busy_ok;
        logic [AW-1:0] base;
        exp_hit = model_access(waddr);
        base = AW'(waddr) & ~AW'(7);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = AW'(waddr);
        beat_cnt  = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!rsp_valid && lat < 400) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        check(busy_ok, "R5 ready low while busy", 32'(busy_ok), 1);
        check(rsp_valid === 1'b1, "R6 response present", 32'(rsp_valid), 1);
        check(rsp_hit === exp_hit, req, 32'(rsp_hit), 32'(exp_hit));
        check(rsp_data === mem_word(AW'(waddr)), "R11 data", rsp_data,
              mem_word(AW'(waddr)));
        if (exp_hit) begin
            check(lat == 2 && beat_cnt == 0, "R3 hit latency/no fill",
                  32'(lat * 100 + beat_cnt), 200);
        end else begin
            check(beat_cnt == 8, "R4 beat count", 32'(beat_cnt), 8);
            for (int i = 0; i < 8 && i < beat_cnt; i++)
                check(beat_log[i] == base + AW'(i), "R4 beat order",
                      32'(beat_log[i]), 32'(base + AW'(i)));
        end
        @(negedge clk);
        check(rsp_valid === 1'b0, "R6 single pulse", 32'(rsp_valid), 0);
    endtask

    task automatic do_inv();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        model_clear();
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int last;
        void'($urandom(32'd1234));
        model_clear();
        repeat (4) @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0,
              "R1 reset outputs", {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);

        // Directed: fill one line, hit inside it.
        do_read(0, "R4 cold miss");
        do_read(3, "R3 hit same line");
        // R2: lines 0..3 of one block share set 0 (and R8 fills free ways).
        do_read(8,  "R8 free way fill");
        do_read(16, "R8 free way fill");
        do_read(24, "R8 free way fill");
        do_read(5,  "R3 hit after fills");
        // R7: line 16 (word 128) also maps to set 0; evicts LRU line 1.
        do_read(128, "R2 same set conflict");
        do_read(17,  "R7 survivor hit");
        do_read(1,   "R7 recently used hit");
        do_read(9,   "R7 LRU victim evicted");
        // R10: set 1 traffic does not disturb set 0.
        do_read(32, "R10 other set miss");
        do_read(40, "R10 other set miss");
        do_read(48, "R10 other set miss");
        do_read(56, "R10 other set miss");
        do_read(288, "R10 other set miss");
        do_read(2,  "R10 set 0 line kept");
        do_read(130, "R10 set 0 line kept");
        // R9: invalidate all, resident lines miss again.
        do_inv();
        do_read(2,  "R9 miss after invalidate");
        do_read(33, "R9 miss after invalidate");

        // Random traffic over a small pool with reuse and occasional flushes.
        last = 0;
        for (int n = 0; n < 300; n++) begin
            int a;
            if ($urandom % 3 == 0) a = (last & ~7) | int'($urandom % 8);
            else a = int'($urandom % 384);
            if ($urandom % 50 == 0) do_inv();
            do_read(a, "R7 random hit flag");
            last = a;
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule